// File: doc/BRIEF.md
# DAC Master Clock Source Selector

This block picks which master clock feeds a multichannel DAC interface. There are three candidates: the main master clock, and the clocks of two on-chip PLLs (A and B). Normally the choice follows the data routing. When DAC1 takes its samples from the S/PDIF receiver, PLL A is chosen, and DACs 2 and 3 are powered down. Any other routing of DAC1 gives the main master clock.

Software can take over the choice with an override enable and a select field. While the receiver is running, only the main master clock may be chosen by hand. A manual request for either PLL, or for the reserved code, is refused. The last accepted selection stays in force, and a sticky error flag is raised. That flag stays set until software clears it.

A new selection does not reach the output at once. It goes through a switchover handshake that models the old clock being gated off for two cycles before the new one is enabled. While this is under way, the busy output is high, and any further change in the wanted source waits until the switch in progress has finished.

Top module: `dac_clksrc_ctrl`

## Requirements
- R1: After reset, `clk_sel` is 2'b00 (main master clock), and `pd_dac2`, `pd_dac3`, `sel_err` and `sw_busy` are all 0.
- R2: With `ovr_en` = 0 and `dac1_src` = 2'b10 (DAC1 fed by the S/PDIF receiver), the applied selection becomes 2'b01 (PLL A), whatever the level of `rcv_on`.
- R3: With `ovr_en` = 0 and `dac1_src` set to any value other than 2'b10, the applied selection becomes 2'b00.
- R4: `pd_dac2` and `pd_dac3` go to 1 one cycle after `ovr_en` = 0 with `dac1_src` = 2'b10 is presented, and go to 0 one cycle after any other combination. Both always carry the same value.
- R5: With `ovr_en` = 1 and `rcv_on` = 0, the applied selection becomes `ovr_sel`, where 2'b00 is the main clock, 2'b01 is PLL A and 2'b10 is PLL B.
- R6: With `ovr_en` = 1, `rcv_on` = 1 and `ovr_sel` other than 2'b00, the request is refused. `clk_sel` keeps its value, no switch starts, and `sel_err` is 1 one cycle later.
- R7: With `ovr_en` = 1 and `ovr_sel` = 2'b11 (reserved), the request is refused in the same way as in R6. `clk_sel` never shows 2'b11.
- R8: `sel_err` is sticky. It clears one cycle after `err_clr` = 1, but only if no refused request is being presented in that same cycle; a refused request wins over the clear.
- R9: When the wanted source differs from `clk_sel` and no switch is in progress, `sw_busy` is 1 for exactly the next two cycles. `clk_sel` takes the new value on the same edge that drops `sw_busy`, three cycles after the stimulus. `clk_sel` never changes unless `sw_busy` was high in the cycle before.
- R10: A change in the wanted source while `sw_busy` is high does not affect the switch in progress. Once that switch completes, a new switch to the latest wanted source starts on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dac1_src | input | 2 | DAC1 data source code; 2'b10 = S/PDIF receiver |
| ovr_en | input | 1 | Manual clock selection enable |
| ovr_sel | input | 2 | Manual clock select code |
| rcv_on | input | 1 | S/PDIF receiver is active |
| err_clr | input | 1 | Clears the sticky selection error |
| clk_sel | output | 2 | Applied clock source code |
| pd_dac2 | output | 1 | Power-down for DAC2 |
| pd_dac3 | output | 1 | Power-down for DAC3 |
| sel_err | output | 1 | Sticky refused-selection flag |
| sw_busy | output | 1 | Switchover handshake in progress |

## Verification
Results of a stimulus arrive at different times. `sel_err`, `pd_dac2`/`pd_dac3` and the rise of `sw_busy` appear one edge after the stimulus is sampled. `sw_busy` stays high on the second edge and drops on the third, which is the same edge that updates `clk_sel`. A change that arrives during a switch is taken up one edge after that switch ends, so its result lands six cycles after the first stimulus.

The driver records the cycle in which it changed the inputs and queues each expected value with the exact cycle in which it is due. The monitor compares outputs at the falling edge of exactly that cycle, so a result that comes early or late counts as a mismatch. The checks during the busy window also confirm that `clk_sel` has not yet moved.

// File: rtl/dac_clksrc_ctrl.sv
module dac_clksrc_ctrl #(
  parameter int SW_GAP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dac1_src,
  input  logic       ovr_en,
  input  logic [1:0] ovr_sel,
  input  logic       rcv_on,
  input  logic       err_clr,
  output logic [1:0] clk_sel,
  output logic       pd_dac2,
  output logic       pd_dac3,
  output logic       sel_err,
  output logic       sw_busy
);
  localparam logic [1:0] CK_MAIN = 2'b00;
  localparam logic [1:0] CK_PLLA = 2'b01;
  localparam logic [1:0] CK_RSVD = 2'b11;
  localparam logic [1:0] SRC_RCV = 2'b10;
  localparam int CW = (SW_GAP > 1) ? $clog2(SW_GAP) : 1;

  logic [1:0]    tgt_q, pend_q, sel_q, cand, want;
  logic [CW-1:0] gap_q;
  logic          busy_q, pd_q, err_q, rcv_route, refused;

  assign rcv_route = (dac1_src == SRC_RCV);
  assign cand      = ovr_en ? ovr_sel : (rcv_route ? CK_PLLA : CK_MAIN);
  assign refused   = ovr_en && ((ovr_sel == CK_RSVD) || (rcv_on && ovr_sel != CK_MAIN));
  assign want      = refused ? tgt_q : cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= CK_MAIN;
      pend_q <= CK_MAIN;
      sel_q  <= CK_MAIN;
      gap_q  <= '0;
      busy_q <= 1'b0;
      pd_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      tgt_q <= want;
      pd_q  <= rcv_route && !ovr_en;
      err_q <= refused || (err_q && !err_clr);
      if (!busy_q) begin
        if (want != sel_q) begin
          busy_q <= 1'b1;
          pend_q <= want;
          gap_q  <= '0;
        end
      end else if (gap_q == CW'(SW_GAP - 1)) begin
        busy_q <= 1'b0;
        sel_q  <= pend_q;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign clk_sel = sel_q;
  assign pd_dac2 = pd_q;
  assign pd_dac3 = pd_q;
  assign sel_err = err_q;
  assign sw_busy = busy_q;
endmodule

// File: rtl/dac_clksrc_ctrl_chk.sv
module dac_clksrc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovr_en,
  input logic [1:0] ovr_sel,
  input logic       rcv_on,
  input logic       err_clr,
  input logic [1:0] clk_sel,
  input logic       pd_dac2,
  input logic       pd_dac3,
  input logic       sel_err,
  input logic       sw_busy
);
  AST_SEL_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n) clk_sel != 2'b11); // R7
  AST_SEL_ONLY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !$stable(clk_sel) |-> $past(sw_busy)); // R9
  AST_BUSY_SECOND: assert property (@(posedge clk) disable iff (!rst_n) $rose(sw_busy) |=> sw_busy); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n) $rose(sw_busy) |=> ##1 !sw_busy); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $fell(sel_err) |-> $past(err_clr)); // R8
  AST_PD_PAIR: assert property (@(posedge clk) disable iff (!rst_n) pd_dac2 == pd_dac3); // R4
  AST_RCV_REFUSE: assert property (@(posedge clk) disable iff (!rst_n) (ovr_en && rcv_on && ovr_sel != 2'b00) |=> sel_err); // R6
endmodule

bind dac_clksrc_ctrl dac_clksrc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .rcv_on(rcv_on),
  .err_clr(err_clr), .clk_sel(clk_sel), .pd_dac2(pd_dac2), .pd_dac3(pd_dac3),
  .sel_err(sel_err), .sw_busy(sw_busy)
);

// File: tb/dac_clksrc_ctrl_bench.sv
module dac_clksrc_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] dac1_src = 2'b00, ovr_sel = 2'b00;
  logic ovr_en = 1'b0, rcv_on = 1'b0, err_clr = 1'b0;
  logic [1:0] clk_sel;
  logic pd_dac2, pd_dac3, sel_err, sw_busy;

  dac_clksrc_ctrl u_dac_clksrc_ctrl (
    .clk(clk), .rst_n(rst_n), .dac1_src(dac1_src), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .rcv_on(rcv_on), .err_clr(err_clr), .clk_sel(clk_sel), .pd_dac2(pd_dac2),
    .pd_dac3(pd_dac3), .sel_err(sel_err), .sw_busy(sw_busy)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    int         what;
    logic [1:0] val;
    string      rq;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int base, input int off, input int what,
                           input logic [1:0] val, input string rq);
    exp_t e;
    e.due = base + off; e.what = what; e.val = val; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic apply(input logic [1:0] src, input logic oen, input logic [1:0] osel,
                       input logic rx, input logic clr, output int base);
    @(negedge clk);
    dac1_src = src; ovr_en = oen; ovr_sel = osel; rcv_on = rx; err_clr = clr;
    base = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // what: 0 = clk_sel, 1 = {pd_dac3, pd_dac2}, 2 = sel_err, 3 = sw_busy
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [1:0] act;
      e = q.pop_front();
      case (e.what)
        0: act = clk_sel;
        1: act = {pd_dac3, pd_dac2};
        2: act = {1'b0, sel_err};
        default: act = {1'b0, sw_busy};
      endcase
      n_cmp++;
      if (e.due != cyc || act !== e.val) begin
        n_bad++;
        $display("FAIL %s item %0d at cycle %0d: actual %b expected %b", e.rq, e.what, cyc, act, e.val);
      end
    end
  end

  initial begin
    int b, b2;
    #23 rst_n = 1'b1;
    apply(2'b00, 0, 2'b00, 0, 0, b);
    expect_at(b, 1, 0, 2'b00, "R1"); expect_at(b, 1, 1, 2'b00, "R1");
    expect_at(b, 1, 2, 2'b00, "R1"); expect_at(b, 1, 3, 2'b00, "R1");
    idle(2);
    // auto: receiver routed to DAC1
    apply(2'b10, 0, 2'b00, 1, 0, b);
    expect_at(b, 1, 3, 2'b01, "R9"); expect_at(b, 1, 1, 2'b11, "R4");
    expect_at(b, 2, 3, 2'b01, "R9"); expect_at(b, 2, 0, 2'b00, "R9");
    expect_at(b, 3, 0, 2'b01, "R2"); expect_at(b, 3, 3, 2'b00, "R9");
    idle(4);
    // manual PLL B while receiver on: refused
    apply(2'b10, 1, 2'b10, 1, 0, b);
    expect_at(b, 1, 2, 2'b01, "R6"); expect_at(b, 1, 1, 2'b00, "R4");
    expect_at(b, 1, 3, 2'b00, "R6"); expect_at(b, 3, 0, 2'b01, "R6");
    idle(4);
    // clear while refusal still present: set wins
    apply(2'b10, 1, 2'b10, 1, 1, b);
    expect_at(b, 1, 2, 2'b01, "R8");
    idle(2);
    // legal manual main clock while receiver on
    apply(2'b10, 1, 2'b00, 1, 0, b);
    expect_at(b, 1, 2, 2'b01, "R8"); expect_at(b, 3, 0, 2'b00, "R5");
    idle(4);
    apply(2'b10, 1, 2'b00, 1, 1, b);
    expect_at(b, 1, 2, 2'b00, "R8");
    idle(2);
    // manual PLL B, receiver off
    apply(2'b10, 1, 2'b10, 0, 0, b);
    expect_at(b, 3, 0, 2'b10, "R5");
    idle(4);
    // reserved code
    apply(2'b10, 1, 2'b11, 0, 0, b);
    expect_at(b, 1, 2, 2'b01, "R7"); expect_at(b, 1, 3, 2'b00, "R7");
    expect_at(b, 3, 0, 2'b10, "R7");
    idle(4);
    apply(2'b10, 1, 2'b10, 0, 1, b);
    expect_at(b, 1, 2, 2'b00, "R8");
    idle(2);
    // change during busy
    apply(2'b10, 1, 2'b01, 0, 0, b);
    apply(2'b10, 1, 2'b00, 0, 0, b2);
    expect_at(b, 2, 0, 2'b10, "R10"); expect_at(b, 3, 0, 2'b01, "R10");
    expect_at(b, 3, 3, 2'b00, "R10"); expect_at(b, 4, 3, 2'b01, "R10");
    expect_at(b, 6, 0, 2'b00, "R10");
    idle(7);
    // auto, other routings
    apply(2'b00, 0, 2'b00, 0, 0, b);
    expect_at(b, 1, 3, 2'b00, "R3"); expect_at(b, 1, 1, 2'b00, "R4");
    expect_at(b, 3, 0, 2'b00, "R3");
    idle(4);
    apply(2'b10, 0, 2'b00, 0, 0, b);
    expect_at(b, 3, 0, 2'b01, "R2");
    idle(4);
    apply(2'b01, 0, 2'b00, 1, 0, b);
    expect_at(b, 1, 1, 2'b00, "R4"); expect_at(b, 3, 0, 2'b00, "R3");
    idle(6);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule